// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary pointing-device channel, and the single output buffer that a host reads through the controller's data port. Each source presents a level that says it has a byte ready, along with the byte itself. The block registers those levels into a two-bit pending mask. From that mask and the controller's mode byte it derives the buffer-full flags for the status byte, the matching mirror bits for the output-port byte, and the two interrupt levels.

The keyboard always has priority. The auxiliary channel owns the buffer only when it is the sole source with data waiting. In that case the auxiliary-full flag and the auxiliary interrupt may assert. A strobe on the data-port read captures the byte of the owning source into a held read register. In the same cycle the block sends a one-cycle pop pulse back to that source so that it can advance. When nothing is pending, a read returns the last byte delivered from the keyboard and pops neither source.

The flags and interrupts are combinational in the pending mask and in the mode input. A change to the mode byte, such as a keyboard disable or enable, therefore takes effect in the same cycle. A change to a source's ready level takes effect one clock later.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset, stat_flags, oport_flags, rd_data, kbd_pop, aux_pop, irq_kbd and irq_aux are all zero.
- R2: The pending mask holds bit 0 = keyboard ready and bit 1 = auxiliary ready. Each bit copies its source's ready input at every rising clock edge, so a change on an input reaches the outputs one cycle later.
- R3: stat_flags bit 0 and oport_flags bit 4 are 1 exactly when at least one pending bit is set.
- R4: stat_flags bit 5 and oport_flags bit 5 are 1 exactly when the pending mask is 2'b10 (auxiliary alone). All other bits of stat_flags and oport_flags are always 0.
- R5: irq_aux is 1 exactly when the pending mask is 2'b10 and mode_reg bit 1 is 1.
- R6: irq_kbd is 1 exactly when pending bit 0 is 1, mode_reg bit 0 is 1 and mode_reg bit 4 (keyboard disable) is 0. The other mode bits have no effect on any output.
- R7: A change on mode_reg changes the flags and interrupts in the same cycle, with no clock edge needed.
- R8: When rd_strobe is high at a rising edge, rd_data takes aux_byte after that edge if the pending mask is 2'b10. Otherwise, if pending bit 0 is set, it takes kbd_byte.
- R9: A read sets kbd_pop or aux_pop, whichever source supplied the byte, for exactly the one cycle after the strobe edge. The two pops are never high together, and neither is high without a read.
- R10: A read while nothing is pending returns the keyboard byte captured by the most recent keyboard-sourced read (zero after reset) and pops no source.
- R11: rd_data holds its value across every edge at which rd_strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_avail | input | 1 | Keyboard source has a byte ready |
| kbd_byte | input | DATA_W | Keyboard source byte |
| aux_avail | input | 1 | Auxiliary source has a byte ready |
| aux_byte | input | DATA_W | Auxiliary source byte |
| mode_reg | input | MODE_W | Controller mode byte |
| rd_strobe | input | 1 | Data-port read, one cycle |
| stat_flags | output | STAT_W | Status-byte flag bits (full at bit 0, auxiliary full at bit 5) |
| oport_flags | output | OPORT_W | Output-port mirror bits (full at bit 4, auxiliary full at bit 5) |
| rd_data | output | DATA_W | Byte returned by the last read |
| kbd_pop | output | 1 | Advance strobe toward the keyboard source |
| aux_pop | output | 1 | Advance strobe toward the auxiliary source |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit mode byte, and the flag positions listed in the requirements. At that size it can sweep all four pending masks against every combination of the three mode bits that matter, with unrelated mode bits toggled alongside. Each combination is followed by a read. This covers every ownership case, every interrupt gating, the no-source read that returns the held keyboard byte, and same-cycle mode flips, with the expected values computed in the bench from the priority rule.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_KBD  = 2'd1,
    SRC_AUX  = 2'd2
  } src_e;

  // keyboard wins whenever it has data
  function automatic src_e pick_source(input logic [1:0] pend);
    if (pend[0])      return SRC_KBD;
    else if (pend[1]) return SRC_AUX;
    else              return SRC_NONE;
  endfunction

  function automatic logic any_pending(input logic [1:0] pend);
    return |pend;
  endfunction

  function automatic logic aux_alone(input logic [1:0] pend);
    return pend[1] & ~pend[0];
  endfunction

endpackage

// File: rtl/obuf_arb_pending.sv
module obuf_arb_pending (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_avail,
  input  logic       aux_avail,
  output logic [1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 2'b00;
    else        pend <= {aux_avail, kbd_avail};
  end
endmodule

// File: rtl/obuf_arb_flags.sv
module obuf_arb_flags
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W         = 8,
  parameter int STAT_W         = 8,
  parameter int OPORT_W        = 8,
  parameter int KBD_IRQ_EN_BIT = 0,
  parameter int AUX_IRQ_EN_BIT = 1,
  parameter int KBD_OFF_BIT    = 4,
  parameter int ST_FULL_BIT    = 0,
  parameter int ST_AUX_BIT     = 5,
  parameter int OP_FULL_BIT    = 4,
  parameter int OP_AUX_BIT     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pend,
  input  logic [MODE_W-1:0]  mode_reg,
  output logic [STAT_W-1:0]  stat_flags,
  output logic [OPORT_W-1:0] oport_flags,
  output logic               irq_kbd,
  output logic               irq_aux
);
  logic full_w;
  logic aux_full_w;
  logic kbd_gate_w;

  assign full_w     = any_pending(pend);
  assign aux_full_w = aux_alone(pend);
  assign kbd_gate_w = mode_reg[KBD_IRQ_EN_BIT] & ~mode_reg[KBD_OFF_BIT];

  for (genvar g = 0; g < STAT_W; g++) begin : g_stat
    if (g == ST_FULL_BIT) begin : g_full
      assign stat_flags[g] = full_w;
    end else if (g == ST_AUX_BIT) begin : g_aux
      assign stat_flags[g] = aux_full_w;
    end else begin : g_zero
      assign stat_flags[g] = 1'b0;
    end
  end

  for (genvar g = 0; g < OPORT_W; g++) begin : g_oport
    if (g == OP_FULL_BIT) begin : g_full
      assign oport_flags[g] = full_w;
    end else if (g == OP_AUX_BIT) begin : g_aux
      assign oport_flags[g] = aux_full_w;
    end else begin : g_zero
      assign oport_flags[g] = 1'b0;
    end
  end

  assign irq_kbd = pend[0] & kbd_gate_w;
  assign irq_aux = aux_full_w & mode_reg[AUX_IRQ_EN_BIT];

  p_aux_implies_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flags[ST_AUX_BIT] |-> (stat_flags[ST_FULL_BIT] && oport_flags[OP_AUX_BIT]));
  p_irq_aux_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> stat_flags[ST_AUX_BIT]);
  p_irq_kbd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd |-> (!mode_reg[KBD_OFF_BIT] && stat_flags[ST_FULL_BIT]));
  p_irq_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux));
endmodule

// File: rtl/obuf_arb_read.sv
module obuf_arb_read
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pend,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] kbd_byte,
  input  logic [DATA_W-1:0] aux_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              kbd_pop,
  output logic              aux_pop
);
  src_e              owner_w;
  logic [DATA_W-1:0] last_kbd_q;
  logic [DATA_W-1:0] pick_byte_w;

  assign owner_w = pick_source(pend);

  always_comb begin
    case (owner_w)
      SRC_KBD: pick_byte_w = kbd_byte;
      SRC_AUX: pick_byte_w = aux_byte;
      default: pick_byte_w = last_kbd_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      last_kbd_q <= '0;
      kbd_pop    <= 1'b0;
      aux_pop    <= 1'b0;
    end else begin
      kbd_pop <= rd_strobe && (owner_w == SRC_KBD);
      aux_pop <= rd_strobe && (owner_w == SRC_AUX);
      if (rd_strobe) begin
        rd_data <= pick_byte_w;
        if (owner_w == SRC_KBD) last_kbd_q <= kbd_byte;
      end
    end
  end

  p_pop_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_pop, aux_pop}));
  p_pop_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !(kbd_pop || aux_pop));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int MODE_W         = 8,
  parameter int STAT_W         = 8,
  parameter int OPORT_W        = 8,
  parameter int KBD_IRQ_EN_BIT = 0,
  parameter int AUX_IRQ_EN_BIT = 1,
  parameter int KBD_OFF_BIT    = 4,
  parameter int ST_FULL_BIT    = 0,
  parameter int ST_AUX_BIT     = 5,
  parameter int OP_FULL_BIT    = 4,
  parameter int OP_AUX_BIT     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kbd_avail,
  input  logic [DATA_W-1:0]  kbd_byte,
  input  logic               aux_avail,
  input  logic [DATA_W-1:0]  aux_byte,
  input  logic [MODE_W-1:0]  mode_reg,
  input  logic               rd_strobe,
  output logic [STAT_W-1:0]  stat_flags,
  output logic [OPORT_W-1:0] oport_flags,
  output logic [DATA_W-1:0]  rd_data,
  output logic               kbd_pop,
  output logic               aux_pop,
  output logic               irq_kbd,
  output logic               irq_aux
);
  logic [1:0] pend_w;

  obuf_arb_pending u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .kbd_avail (kbd_avail),
    .aux_avail (aux_avail),
    .pend      (pend_w)
  );

  obuf_arb_flags #(
    .MODE_W(MODE_W), .STAT_W(STAT_W), .OPORT_W(OPORT_W),
    .KBD_IRQ_EN_BIT(KBD_IRQ_EN_BIT), .AUX_IRQ_EN_BIT(AUX_IRQ_EN_BIT),
    .KBD_OFF_BIT(KBD_OFF_BIT), .ST_FULL_BIT(ST_FULL_BIT), .ST_AUX_BIT(ST_AUX_BIT),
    .OP_FULL_BIT(OP_FULL_BIT), .OP_AUX_BIT(OP_AUX_BIT)
  ) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend_w),
    .mode_reg    (mode_reg),
    .stat_flags  (stat_flags),
    .oport_flags (oport_flags),
    .irq_kbd     (irq_kbd),
    .irq_aux     (irq_aux)
  );

  obuf_arb_read #(.DATA_W(DATA_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_w),
    .rd_strobe (rd_strobe),
    .kbd_byte  (kbd_byte),
    .aux_byte  (aux_byte),
    .rd_data   (rd_data),
    .kbd_pop   (kbd_pop),
    .aux_pop   (aux_pop)
  );

  p_full_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_avail || aux_avail) |=> stat_flags[ST_FULL_BIT]);
  p_empty_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_avail && !aux_avail) |=> (!stat_flags[ST_FULL_BIT] && !oport_flags[OP_FULL_BIT]));
  p_kbd_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && stat_flags[ST_FULL_BIT] && !stat_flags[ST_AUX_BIT]) |=> kbd_pop);
endmodule

// File: tb/obuf_arbiter_tb.sv
module obuf_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_avail = 1'b0, aux_avail = 1'b0, rd_strobe = 1'b0;
  logic [7:0] kbd_byte = '0, aux_byte = '0, mode_reg = '0;
  logic [7:0] stat_flags, oport_flags, rd_data;
  logic       kbd_pop, aux_pop, irq_kbd, irq_aux;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  obuf_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .kbd_avail(kbd_avail), .kbd_byte(kbd_byte),
    .aux_avail(aux_avail), .aux_byte(aux_byte), .mode_reg(mode_reg),
    .rd_strobe(rd_strobe), .stat_flags(stat_flags), .oport_flags(oport_flags),
    .rd_data(rd_data), .kbd_pop(kbd_pop), .aux_pop(aux_pop),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_flags(input logic kp, input logic ap, input logic [7:0] m);
    logic full, alone;
    full  = kp | ap;
    alone = ap & ~kp;
    chk("R3", "stat full", stat_flags[0], full);
    chk("R4", "stat vector", stat_flags, {2'b00, alone, 4'b0000, full});
    chk("R4", "oport vector", oport_flags, {2'b00, alone, full, 4'b0000});
    chk("R5", "irq_aux", irq_aux, alone & m[1]);
    chk("R6", "irq_kbd", irq_kbd, kp & m[0] & ~m[4]);
  endtask

  initial begin
    logic [7:0] last_kbd;
    logic [7:0] exp_rd;
    last_kbd = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "stat", stat_flags, 0);
    chk("R1", "oport", oport_flags, 0);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "pops", {kbd_pop, aux_pop}, 0);
    chk("R1", "irqs", {irq_kbd, irq_aux}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int rep = 0; rep < 2; rep++) begin
      for (int p = 0; p < 4; p++) begin
        for (int m = 0; m < 8; m++) begin
          logic [7:0] md;
          logic kp, ap;
          kp = p[0]; ap = p[1];
          md = {1'b0, (rep == 1), 1'b0, m[2], (rep == 1), (rep == 0), m[1], m[0]};
          kbd_avail = kp; aux_avail = ap; mode_reg = md;
          kbd_byte = 8'h10 + 8'(p * 8 + m) + 8'(rep * 64);
          aux_byte = 8'h80 + 8'(p * 8 + m) + 8'(rep * 64);
          @(negedge clk);
          check_flags(kp, ap, md);   // R2: ready levels visible one edge later
          rd_strobe = 1'b1;
          @(negedge clk);
          rd_strobe = 1'b0;
          if (kp) begin exp_rd = kbd_byte; last_kbd = kbd_byte; end
          else if (ap) exp_rd = aux_byte;
          else exp_rd = last_kbd;      // R10
          chk("R8", "rd_data", rd_data, exp_rd);
          chk("R9", "kbd_pop", kbd_pop, kp);
          chk("R9", "aux_pop", aux_pop, ap & ~kp);
          kbd_byte = ~kbd_byte; aux_byte = ~aux_byte;
          @(negedge clk);
          chk("R9", "pops dropped", {kbd_pop, aux_pop}, 0);
          chk("R11", "rd_data held", rd_data, exp_rd);
          // R7: flip keyboard disable and aux enable without a clock edge
          mode_reg = md ^ 8'h12;
          #0.5;
          check_flags(kp, ap, md ^ 8'h12);
          chk("R7", "irq_kbd same cycle", irq_kbd, kp & md[0] & ~(md[4] ^ 1'b1));
        end
      end
    end

    // R2: pending drop reaches outputs one edge later, not before
    kbd_avail = 1'b1; aux_avail = 1'b0; mode_reg = 8'h01;
    @(negedge clk);
    kbd_avail = 1'b0;
    #0.5;
    chk("R2", "full still set before edge", stat_flags[0], 1);
    @(negedge clk);
    chk("R2", "full clear after edge", stat_flags[0], 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule